// File: doc/BRIEF.md
# Received Frame Type Decoder

This block sits behind a serial-to-parallel demultiplexer in a link receiver. On each frame strobe it reads the 4-bit control field of the received word and classifies the frame as data, control or fill. The same control field also says whether the transmitter sent the payload complemented. The block then restores the payload to its true polarity and raises the matching active-low "available" output. Codes outside the legal set are reported on an error output for the link state machine, and no frame is delivered for them.

The top bit of the data field doubles as a flag. With flag restore selected, the flag is delivered in its true polarity. Otherwise, in double-frame mode, it is passed through untouched as an even/odd frame marker. All outputs are registered and change only in the cycle after a frame strobe.

Top module: `frame_class_decoder`

## Requirements
- R1: Control code 4'b1101 marks a true-polarity data frame: `dat_avail_n` goes low, `ctl_avail_n` stays high and `data_out` equals the data field.
- R2: Control code 4'b0010 marks an inverted data frame: `dat_avail_n` goes low and `data_out` is the bitwise complement of the data field.
- R3: Control code 4'b1001 marks a true control frame and 4'b0110 an inverted control frame: `ctl_avail_n` goes low, `dat_avail_n` stays high, and `data_out` is the data field (1001) or its complement (0110).
- R4: Control codes 4'b0101 and 4'b1010 are fill frames: both available outputs are high, `code_err` is low, `flag_out` is 0 and `data_out` keeps its previous value.
- R5: Any other control code drives `code_err` high for that frame, with both available outputs high, `flag_out` 0 and `data_out` unchanged. The next legal frame clears `code_err`.
- R6: `ctl_avail_n` and `dat_avail_n` are never low together.
- R7: The flag bit is bit DATA_W-1 of the data field. With `flag_restore_en` high, on data and control frames `flag_out` is that bit complemented when the frame is inverted and passed unchanged otherwise.
- R8: With `flag_restore_en` low and `dbl_frame_en` high, on data and control frames `flag_out` is the received flag bit, passed unchanged whatever the polarity.
- R9: With both `flag_restore_en` and `dbl_frame_en` low, `flag_out` is 0.
- R10: Outputs change only in the clock cycle after `frm_stb` is sampled high. They hold while `frm_stb` is low, whatever the other inputs do.
- R11: While `rst_n` is low: both available outputs are high, and `code_err`, `flag_out` and `data_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_stb | input | 1 | One-cycle strobe: a new frame is present on the field inputs |
| ctrl_fld | input | 4 | Control field of the received frame |
| data_fld | input | DATA_W | Data field of the received frame; top bit is the flag |
| flag_restore_en | input | 1 | Deliver the flag bit in true polarity |
| dbl_frame_en | input | 1 | Double-frame mode: flag is an even/odd marker |
| ctl_avail_n | output | 1 | Low when the last frame carried control information |
| dat_avail_n | output | 1 | Low when the last frame carried data |
| data_out | output | DATA_W | Restored payload |
| flag_out | output | 1 | Restored flag or frame-parity marker |
| code_err | output | 1 | High for a frame with an illegal control code |

## Verification
A wrong decode entry shows up at the outputs one clock after the strobe of the frame that uses that code. It appears as a wrong available line, a payload of the wrong polarity or a spurious error. An output register that loads without a strobe, or fails to hold through a fill or error frame, shows up as a changed `data_out` at the next sample. That sample is taken either between strobes or after the following fill frame. Every frame kind and flag mode is therefore checked in the cycle after its strobe, and once more before the next strobe.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int CTRL_W = 4;

    typedef enum logic [1:0] {
        FK_FILL = 2'd0,
        FK_DATA = 2'd1,
        FK_CTRL = 2'd2,
        FK_ERR  = 2'd3
    } frame_kind_e;

    typedef struct packed {
        frame_kind_e kind;
        logic        inv;
    } code_info_t;

endpackage

// File: rtl/fcd_code_decode.sv
module fcd_code_decode
    import fcd_pkg::*;
(
    input  logic [CTRL_W-1:0] code,
    output code_info_t        info
);

    always_comb begin
        info.kind = FK_ERR;
        info.inv  = 1'b0;
        unique case (code)
            4'b1101: begin info.kind = FK_DATA; info.inv = 1'b0; end
            4'b0010: begin info.kind = FK_DATA; info.inv = 1'b1; end
            4'b1001: begin info.kind = FK_CTRL; info.inv = 1'b0; end
            4'b0110: begin info.kind = FK_CTRL; info.inv = 1'b1; end
            4'b0101,
            4'b1010: begin info.kind = FK_FILL; info.inv = 1'b0; end
            default: begin info.kind = FK_ERR;  info.inv = 1'b0; end
        endcase
    end

endmodule

// File: rtl/fcd_payload_restore.sv
module fcd_payload_restore #(
    parameter int WIDTH = 20
) (
    input  logic             inv,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] restored
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign restored[b] = raw[b] ^ inv;
    end

endmodule

// File: rtl/fcd_flag_select.sv
module fcd_flag_select
    import fcd_pkg::*;
(
    input  frame_kind_e kind,
    input  logic        inv,
    input  logic        raw_flag,
    input  logic        restore_en,
    input  logic        dbl_en,
    output logic        flag
);

    logic carries_payload;

    assign carries_payload = (kind == FK_DATA) || (kind == FK_CTRL);

    always_comb begin
        flag = 1'b0;
        if (carries_payload) begin
            if (restore_en) begin
                flag = raw_flag ^ inv;
            end else if (dbl_en) begin
                flag = raw_flag;
            end
        end
    end

endmodule

// File: rtl/frame_class_decoder.sv
module frame_class_decoder
    import fcd_pkg::*;
#(
    parameter int DATA_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_stb,
    input  logic [3:0]        ctrl_fld,
    input  logic [DATA_W-1:0] data_fld,
    input  logic              flag_restore_en,
    input  logic              dbl_frame_en,
    output logic              ctl_avail_n,
    output logic              dat_avail_n,
    output logic [DATA_W-1:0] data_out,
    output logic              flag_out,
    output logic              code_err
);

    localparam int FLAG_POS = DATA_W - 1;

    typedef struct packed {
        logic              ctl_n;
        logic              dat_n;
        logic              err;
        logic              flag;
        logic [DATA_W-1:0] data;
    } out_state_t;

    localparam out_state_t RESET_STATE = '{
        ctl_n: 1'b1,
        dat_n: 1'b1,
        err:   1'b0,
        flag:  1'b0,
        data:  '0
    };

    code_info_t        info;
    logic [DATA_W-1:0] restored;
    logic              flag_sel;
    out_state_t        st_d, st_q;

    fcd_code_decode u_code (
        .code (ctrl_fld),
        .info (info)
    );

    fcd_payload_restore #(.WIDTH(DATA_W)) u_restore (
        .inv      (info.inv),
        .raw      (data_fld),
        .restored (restored)
    );

    fcd_flag_select u_flag (
        .kind       (info.kind),
        .inv        (info.inv),
        .raw_flag   (data_fld[FLAG_POS]),
        .restore_en (flag_restore_en),
        .dbl_en     (dbl_frame_en),
        .flag       (flag_sel)
    );

    always_comb begin
        st_d = st_q;
        if (frm_stb) begin
            st_d.ctl_n = 1'b1;
            st_d.dat_n = 1'b1;
            st_d.err   = 1'b0;
            st_d.flag  = flag_sel;
            unique case (info.kind)
                FK_DATA: begin
                    st_d.dat_n = 1'b0;
                    st_d.data  = restored;
                end
                FK_CTRL: begin
                    st_d.ctl_n = 1'b0;
                    st_d.data  = restored;
                end
                FK_ERR: begin
                    st_d.err = 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_avail_n = st_q.ctl_n;
    assign dat_avail_n = st_q.dat_n;
    assign code_err    = st_q.err;
    assign flag_out    = st_q.flag;
    assign data_out    = st_q.data;

endmodule

// File: rtl/fcd_chk.sv
module fcd_chk #(
    parameter int DATA_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frm_stb,
    input logic [3:0]        ctrl_fld,
    input logic [DATA_W-1:0] data_fld,
    input logic              flag_restore_en,
    input logic              dbl_frame_en,
    input logic              ctl_avail_n,
    input logic              dat_avail_n,
    input logic [DATA_W-1:0] data_out,
    input logic              flag_out,
    input logic              code_err
);

    logic legal_code;
    assign legal_code = (ctrl_fld == 4'b1101) || (ctrl_fld == 4'b0010) ||
                        (ctrl_fld == 4'b1001) || (ctrl_fld == 4'b0110) ||
                        (ctrl_fld == 4'b0101) || (ctrl_fld == 4'b1010);

    // R1
    true_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_stb && ctrl_fld == 4'b1101 |=>
            !dat_avail_n && ctl_avail_n && data_out == $past(data_fld));

    // R2
    inv_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_stb && ctrl_fld == 4'b0010 |=>
            !dat_avail_n && data_out == ~$past(data_fld));

    // R3
    inv_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_stb && ctrl_fld == 4'b0110 |=>
            !ctl_avail_n && dat_avail_n && data_out == ~$past(data_fld));

    // R4
    fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_stb && (ctrl_fld == 4'b0101 || ctrl_fld == 4'b1010) |=>
            ctl_avail_n && dat_avail_n && !code_err && $stable(data_out));

    // R5
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_stb && !legal_code |=>
            code_err && ctl_avail_n && dat_avail_n && !flag_out && $stable(data_out));

    // R6
    avail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ctl_avail_n && !dat_avail_n));

    // R8
    parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_stb && !flag_restore_en && dbl_frame_en && ctrl_fld == 4'b0010 |=>
            flag_out == $past(data_fld[DATA_W-1]));

    // R10
    no_stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_stb |=> $stable(data_out) && $stable(ctl_avail_n) &&
                     $stable(dat_avail_n) && $stable(code_err) && $stable(flag_out));

endmodule

bind frame_class_decoder fcd_chk #(.DATA_W(DATA_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .frm_stb         (frm_stb),
    .ctrl_fld        (ctrl_fld),
    .data_fld        (data_fld),
    .flag_restore_en (flag_restore_en),
    .dbl_frame_en    (dbl_frame_en),
    .ctl_avail_n     (ctl_avail_n),
    .dat_avail_n     (dat_avail_n),
    .data_out        (data_out),
    .flag_out        (flag_out),
    .code_err        (code_err)
);

// File: tb/frame_class_decoder_tb.sv
module frame_class_decoder_tb;

    localparam int DW = 20;
    localparam int NV = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frm_stb = 1'b0;
    logic [3:0]    ctrl_fld = 4'h0;
    logic [DW-1:0] data_fld = '0;
    logic          flag_restore_en = 1'b0;
    logic          dbl_frame_en = 1'b0;
    logic          ctl_avail_n, dat_avail_n, flag_out, code_err;
    logic [DW-1:0] data_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    frame_class_decoder #(.DATA_W(DW)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .frm_stb         (frm_stb),
        .ctrl_fld        (ctrl_fld),
        .data_fld        (data_fld),
        .flag_restore_en (flag_restore_en),
        .dbl_frame_en    (dbl_frame_en),
        .ctl_avail_n     (ctl_avail_n),
        .dat_avail_n     (dat_avail_n),
        .data_out        (data_out),
        .flag_out        (flag_out),
        .code_err        (code_err)
    );

    // {ctrl, data, restore, dbl, exp ctl_n, exp dat_n, exp err, exp data, exp flag}
    localparam logic [49:0] VECS [0:NV-1] = '{
        {4'hD, 20'h12345, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 20'h12345, 1'b0}, // R1
        {4'h2, 20'h12345, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 20'hEDCBA, 1'b1}, // R2 R7
        {4'h9, 20'hABCDE, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 20'hABCDE, 1'b1}, // R3 R7
        {4'h6, 20'hABCDE, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 20'h54321, 1'b1}, // R3 R8
        {4'h5, 20'hFFFFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 20'h54321, 1'b0}, // R4
        {4'hA, 20'h00000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 20'h54321, 1'b0}, // R4
        {4'h0, 20'h11111, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 20'h54321, 1'b0}, // R5
        {4'hF, 20'h22222, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 20'h54321, 1'b0}, // R5
        {4'hD, 20'h80000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 20'h80000, 1'b1}, // R1 R8
        {4'h2, 20'h80000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 20'h7FFFF, 1'b1}, // R2 R8
        {4'h2, 20'h80000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 20'h7FFFF, 1'b0}, // R2 R7
        {4'h9, 20'h7FFFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 20'h7FFFF, 1'b0}  // R3 R9
    };

    task automatic check(input string req, input logic e_ctl, input logic e_dat,
                         input logic e_err, input logic [DW-1:0] e_data, input logic e_flag);
        n_run++;
        if (ctl_avail_n !== e_ctl || dat_avail_n !== e_dat || code_err !== e_err ||
            data_out !== e_data || flag_out !== e_flag) begin
            n_fail++;
            $display("FAIL %s: got ctl_n=%b dat_n=%b err=%b data=%h flag=%b, expected ctl_n=%b dat_n=%b err=%b data=%h flag=%b",
                     req, ctl_avail_n, dat_avail_n, code_err, data_out, flag_out,
                     e_ctl, e_dat, e_err, e_data, e_flag);
        end
    endtask

    task automatic send(input logic [3:0] c, input logic [DW-1:0] d,
                        input logic fr, input logic db);
        @(negedge clk);
        ctrl_fld = c; data_fld = d; flag_restore_en = fr; dbl_frame_en = db;
        frm_stb = 1'b1;
        @(negedge clk);
        frm_stb = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: state during reset
        check("R11", 1'b1, 1'b1, 1'b0, '0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            send(VECS[i][49:46], VECS[i][45:26], VECS[i][25], VECS[i][24]);
            check($sformatf("R1-R9 vec%0d", i), VECS[i][23], VECS[i][22],
                  VECS[i][21], VECS[i][20:1], VECS[i][0]);
        end

        // R10: inputs move without a strobe, outputs must hold
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            ctrl_fld = 4'hD; data_fld = 20'h0F0F0 + k;
            flag_restore_en = 1'b1; dbl_frame_en = 1'b1;
        end
        @(negedge clk);
        check("R10 hold", 1'b0, 1'b1, 1'b0, 20'h7FFFF, 1'b0);

        // R5: error frame, then a legal frame clears the error
        send(4'h3, 20'h33333, 1'b0, 1'b0);
        check("R5 err", 1'b1, 1'b1, 1'b1, 20'h7FFFF, 1'b0);
        repeat (3) @(negedge clk);
        check("R5 err held", 1'b1, 1'b1, 1'b1, 20'h7FFFF, 1'b0);
        send(4'hD, 20'h0000F, 1'b0, 1'b0);
        check("R5 cleared", 1'b1, 1'b0, 1'b0, 20'h0000F, 1'b0);

        // R9: inverted control with both flag modes off
        send(4'h6, 20'h80001, 1'b0, 1'b0);
        check("R9", 1'b0, 1'b1, 1'b0, 20'h7FFFE, 1'b0);

        // R4: fill after data keeps payload
        send(4'hA, 20'hAAAAA, 1'b1, 1'b0);
        check("R4 fill", 1'b1, 1'b1, 1'b0, 20'h7FFFE, 1'b0);

        // R11: reset mid-run
        send(4'h9, 20'h12121, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R11 mid-run", 1'b1, 1'b1, 1'b0, '0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after release", 1'b1, 1'b1, 1'b0, '0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule